// File: doc/BRIEF.md
# Digital PWM Switching-Cycle Oscillator with Half-Period Synchronization

This block sets the switching cycle of a digital PWM controller. A counter runs from zero to a programmable period minus one and then wraps. Its value is the sawtooth that a PWM comparator compares with a duty value, and a one-clock strobe marks each new cycle. The period defaults to 200 system clocks, which is 250 kHz at 50 MHz. A configuration input can shorten it down to 50 clocks (1 MHz), but cannot lengthen it past the default.

While it runs on its own, the block emits a short synchronization pulse in the middle of each cycle. It also watches a synchronization input. The input is resynchronized and edge-detected, and a rising edge that arrives before the internal cycle would end restarts the cycle on that edge. This cuts the sawtooth short. Edges caused by the block's own pulse are masked, so the output and the input can share one wire-ORed line.

When two instances share that line, the one with the shorter period stays in charge. The other instance restarts on each of its pulses, runs half a period behind it (plus the synchronizer latency), and stops emitting pulses of its own.

Top module: `pwm_sync_osc`

## Requirements
- R1: While reset is asserted, ramp is 0, cycle_start is 1 and sync_out is 0. The first cycle after reset lasts DEFAULT_PERIOD (200) clocks.
- R2: Without accepted sync edges, ramp counts up by one per clock from 0 to P-1 and then returns to 0. cycle_start is 1 exactly when ramp is 0.
- R3: The period P of a cycle is period_cfg clamped to the range MIN_PERIOD (50) to DEFAULT_PERIOD (200). It is sampled on the clock edge that starts the cycle.
- R4: While the block is master, sync_out is high for PULSE_CLKS (6) clocks, starting in the clock where ramp equals floor(P/2).
- R5: Take the first rising clock edge that samples sync_in at 1 after a 0 sample. If the edge is accepted, ramp reads 0 after the third rising clock edge counted from that one, and a new cycle begins there.
- R6: An edge is dropped if ramp is below GUARD_CLKS (4) on the clock edge where the restart would take place. The cycle then continues to count normally.
- R7: A cycle restarted by an edge reaches a peak ramp value lower than P-1. The peak is the ramp value held in the clock before the restart.
- R8: After a cycle restarted by an external edge, sync_out stays low until a cycle ends by counting out to P-1. After that, master pulses return.
- R9: A rising edge of sync_in is ignored if sync_out was high in the same clock in which sync_in was sampled high. This lets sync_in be tied to this block's own sync_out.
- R10: Two instances with periods Pm < Ps share one line, with each sync_in driven by the OR of both sync_out. The slower instance then repeats every Pm clocks. Its cycle starts in the clock where the faster instance's ramp is floor(Pm/2)+3, and it emits no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_cfg | input | CNT_W | Requested period in clocks, clamped inside the block |
| sync_in | input | 1 | External synchronization line, asynchronous |
| sync_out | output | 1 | Half-period synchronization pulse (master only) |
| ramp | output | CNT_W | Sawtooth count for the PWM comparator |
| cycle_start | output | 1 | High in the first clock of each switching cycle |

## Verification
Every output is a function of the counter, the latched period and the slave flag. A wrong period latch shows up in the spacing of cycle_start and in the position of the sync pulse within one cycle. A wrong slave flag shows up on sync_out within half a period. An error in the synchronizer or the echo mask moves a restart by a clock, or causes a restart that should not happen. This appears at ramp within three clocks of the line edge, so the bench compares ramp, cycle_start and sync_out in every clock against an independent model. It also measures the phase of two tied instances directly.

// File: rtl/pwm_osc_pkg.sv
package pwm_osc_pkg;

  // Clamp a requested period into the legal window.
  function automatic int unsigned clamp_period(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
    if (req < lo) return lo;
    if (req > hi) return hi;
    return req;
  endfunction

  // Ramp value at which the half-period pulse begins.
  function automatic int unsigned mid_point(input int unsigned per);
    return per / 2;
  endfunction

  // True while count lies in the pulse window of a cycle of length per.
  function automatic logic in_pulse_window(input int unsigned cnt,
                                           input int unsigned per,
                                           input int unsigned len);
    return (cnt >= mid_point(per)) && (cnt < mid_point(per) + len);
  endfunction

  // True when a restart may be taken at this count.
  function automatic logic restart_permitted(input int unsigned cnt,
                                             input int unsigned guard);
    return cnt >= guard;
  endfunction

endpackage

// File: rtl/osc_sync_in.sv
module osc_sync_in #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic own_pulse,
  output logic ext_edge
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] in_pipe;
  logic [SYNC_STAGES-1:0] own_pipe;
  logic                   in_last;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    logic d_in, d_own;
    if (i == 0) begin : g_first
      assign d_in  = sync_in;
      assign d_own = own_pulse;
    end else begin : g_next
      assign d_in  = in_pipe[i-1];
      assign d_own = own_pipe[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        in_pipe[i]  <= 1'b0;
        own_pipe[i] <= 1'b0;
      end else begin
        in_pipe[i]  <= d_in;
        own_pipe[i] <= d_own;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) in_last <= 1'b0;
    else        in_last <= in_pipe[LAST];
  end

  // Rising edge, aligned with the delayed copy of the own pulse (echo mask).
  assign ext_edge = in_pipe[LAST] & ~in_last & ~own_pipe[LAST];

  AST_EDGE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge); // R5

endmodule

// File: rtl/osc_ramp_counter.sv
module osc_ramp_counter
  import pwm_osc_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned DEFAULT_PERIOD = 200,
  parameter int unsigned MIN_PERIOD     = 50,
  parameter int unsigned GUARD_CLKS     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic             ext_edge,
  output logic [CNT_W-1:0] ramp,
  output logic [CNT_W-1:0] cur_period,
  output logic             slave
);
  localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEFAULT_PERIOD);

  logic [CNT_W-1:0] cnt_q, per_q, per_next;
  logic             slave_q;
  logic             at_end, take_ext;

  assign per_next = CNT_W'(clamp_period(32'(period_cfg), MIN_PERIOD, DEFAULT_PERIOD));
  assign at_end   = (cnt_q == per_q - 1'b1);
  assign take_ext = ext_edge && restart_permitted(32'(cnt_q), GUARD_CLKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_q   <= DEF_P;
      slave_q <= 1'b0;
    end else if (take_ext) begin
      cnt_q   <= '0;
      per_q   <= per_next;
      slave_q <= 1'b1;
    end else if (at_end) begin
      cnt_q   <= '0;
      per_q   <= per_next;
      slave_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ramp       = cnt_q;
  assign cur_period = per_q;
  assign slave      = slave_q;

  AST_RAMP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < per_q); // R2
  AST_PERIOD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= CNT_W'(MIN_PERIOD)) && (per_q <= DEF_P)); // R3
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R2

endmodule

// File: rtl/osc_sync_pulse.sv
module osc_sync_pulse
  import pwm_osc_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PULSE_CLKS = 6
) (
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] cur_period,
  input  logic             slave,
  output logic             pulse
);
  logic window;

  assign window = in_pulse_window(32'(ramp), 32'(cur_period), PULSE_CLKS);
  assign pulse  = window & ~slave;

endmodule

// File: rtl/pwm_sync_osc.sv
module pwm_sync_osc
  import pwm_osc_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned DEFAULT_PERIOD = 200,
  parameter int unsigned MIN_PERIOD     = 50,
  parameter int unsigned PULSE_CLKS     = 6,
  parameter int unsigned GUARD_CLKS     = 4,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_cfg,
  input  logic             sync_in,
  output logic             sync_out,
  output logic [CNT_W-1:0] ramp,
  output logic             cycle_start
);
  localparam int unsigned HALF_MIN = MIN_PERIOD / 2;

  initial begin
    if (DEFAULT_PERIOD >= (1 << CNT_W)) $error("period does not fit CNT_W");
    if (MIN_PERIOD > DEFAULT_PERIOD)    $error("minimum above default");
    if (GUARD_CLKS < 2 || GUARD_CLKS >= HALF_MIN) $error("guard out of range");
    if (PULSE_CLKS == 0 || PULSE_CLKS >= HALF_MIN) $error("pulse length out of range");
    if (SYNC_STAGES < 2) $error("need at least two synchronizer stages");
  end

  logic             ext_edge;
  logic             slave;
  logic [CNT_W-1:0] cur_period;

  osc_sync_in #(.SYNC_STAGES(SYNC_STAGES)) u_sync_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_in),
    .own_pulse (sync_out),
    .ext_edge  (ext_edge)
  );

  osc_ramp_counter #(
    .CNT_W          (CNT_W),
    .DEFAULT_PERIOD (DEFAULT_PERIOD),
    .MIN_PERIOD     (MIN_PERIOD),
    .GUARD_CLKS     (GUARD_CLKS)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_cfg (period_cfg),
    .ext_edge   (ext_edge),
    .ramp       (ramp),
    .cur_period (cur_period),
    .slave      (slave)
  );

  osc_sync_pulse #(.CNT_W(CNT_W), .PULSE_CLKS(PULSE_CLKS)) u_pulse (
    .ramp       (ramp),
    .cur_period (cur_period),
    .slave      (slave),
    .pulse      (sync_out)
  );

  assign cycle_start = (ramp == '0);

  AST_EXT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge && (ramp >= CNT_W'(GUARD_CLKS))) |=> (ramp == '0)); // R5
  AST_GUARD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_edge && (ramp < CNT_W'(GUARD_CLKS)) && (ramp != cur_period - 1'b1))
      |=> (ramp == $past(ramp) + 1'b1)); // R6
  AST_NO_EARLY_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start); // R6
  AST_PULSE_AT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> (ramp == cur_period / 2)); // R4
  AST_SLAVE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slave) |-> $past(ext_edge)); // R8

endmodule

// File: tb/sim_pwm_sync_osc.sv
module sim_pwm_sync_osc;
  localparam int W      = 16;
  localparam int DEF    = 200;
  localparam int MINP   = 50;
  localparam int PLEN   = 6;
  localparam int GUARD  = 4;
  localparam int LAT    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  string phase = "R1";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- DUT u0 with reference model ----------------
  logic [W-1:0] cfg0 = W'(DEF);
  logic         drv_sync = 1'b0;
  logic         loop_en  = 1'b0;
  logic         out0, cs0;
  logic [W-1:0] ramp0;
  logic         in0;
  assign in0 = drv_sync | (loop_en & out0);

  pwm_sync_osc u0 (.clk(clk), .rst_n(rst_n), .period_cfg(cfg0), .sync_in(in0),
                   .sync_out(out0), .ramp(ramp0), .cycle_start(cs0));

  int m_cnt, m_per;
  bit m_slave;
  bit qin[$];
  bit qout[$];

  function automatic bit m_out();
    int h = m_per / 2;
    return !m_slave && m_cnt >= h && m_cnt < h + PLEN;
  endfunction

  function automatic int clampi(input int v);
    return v < MINP ? MINP : (v > DEF ? DEF : v);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_per = DEF; m_slave = 0;
      qin = '{0, 0, 0}; qout = '{0, 0, 0};
    end else begin
      bit o_now, i_now, edge_seen;
      o_now = m_out();
      i_now = drv_sync | (loop_en & o_now);
      edge_seen = qin[LAT-2] && !qin[LAT-1] && !qout[LAT-2];
      if (edge_seen && m_cnt >= GUARD) begin
        m_cnt = 0; m_per = clampi(int'(cfg0)); m_slave = 1;
      end else if (m_cnt >= m_per - 1) begin
        m_cnt = 0; m_per = clampi(int'(cfg0)); m_slave = 0;
      end else begin
        m_cnt++;
      end
      qin.push_front(i_now);  void'(qin.pop_back());
      qout.push_front(o_now); void'(qout.pop_back());
    end
  end

  bit model_on = 0;
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check(int'(ramp0) == m_cnt, phase, int'(ramp0), m_cnt);
      check(cs0 == (m_cnt == 0), phase, int'(cs0), int'(m_cnt == 0));
      check(out0 == m_out(), phase, int'(out0), int'(m_out()));
    end
  end

  // ---------------- pair u1 (fast) / u2 (slow) ----------------
  logic [W-1:0] ramp1, ramp2;
  logic out1, out2, cs1, cs2, line;
  assign line = out1 | out2;
  pwm_sync_osc u1 (.clk(clk), .rst_n(rst_n), .period_cfg(W'(100)), .sync_in(line),
                   .sync_out(out1), .ramp(ramp1), .cycle_start(cs1));
  pwm_sync_osc u2 (.clk(clk), .rst_n(rst_n), .period_cfg(W'(160)), .sync_in(line),
                   .sync_out(out2), .ramp(ramp2), .cycle_start(cs2));

  // ---------------- helpers ----------------
  task automatic next_start();
    @(negedge clk);
    while (!cs0) @(negedge clk);
  endtask

  task automatic measure(output int len, output int mid, output int width);
    len = 0; mid = -1; width = 0;
    do begin
      if (out0) begin
        width++;
        if (mid < 0) mid = int'(ramp0);
      end
      len++;
      @(negedge clk);
    end while (!cs0);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int len, mid, wid, peak, cnt_hi;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ramp0 == 0, "R1", int'(ramp0), 0);
    check(cs0 == 1, "R1", int'(cs0), 1);
    check(out0 == 0, "R1", int'(out0), 0);
    rst_n = 1'b1;
    model_on = 1;

    // R1 / R2 default period
    phase = "R2";
    measure(len, mid, wid);
    check(len == DEF, "R1", len, DEF);
    measure(len, mid, wid);
    check(len == DEF, "R2", len, DEF);
    // R4 pulse placement and width
    check(mid == DEF / 2, "R4", mid, DEF / 2);
    check(wid == PLEN, "R4", wid, PLEN);

    // R3 clamp below minimum
    phase = "R3";
    cfg0 = W'(10);
    next_start();
    measure(len, mid, wid);
    check(len == MINP, "R3", len, MINP);
    check(mid == MINP / 2, "R4", mid, MINP / 2);
    cfg0 = W'(300);
    next_start();
    measure(len, mid, wid);
    check(len == DEF, "R3", len, DEF);
    cfg0 = W'(120);
    next_start();
    measure(len, mid, wid);
    check(len == 120, "R3", len, 120);
    check(mid == 60, "R4", mid, 60);

    // R5 / R7 external restart at ramp 30
    phase = "R5";
    while (ramp0 != 30) @(negedge clk);
    drv_sync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    peak = int'(ramp0);
    @(negedge clk);
    check(ramp0 == 0, "R5", int'(ramp0), 0);
    check(peak == 32, "R7", peak, 32);
    check(peak < 119, "R7", peak, 119);

    // R8 slave cycle silent, then master pulses return
    phase = "R8";
    cnt_hi = 0; len = 0;
    do begin
      if (len == 5) drv_sync = 1'b0;
      if (out0) cnt_hi++;
      len++;
      @(negedge clk);
    end while (!cs0);
    check(cnt_hi == 0, "R8", cnt_hi, 0);
    check(len == 120, "R8", len, 120);
    measure(len, mid, wid);
    check(wid == PLEN, "R8", wid, PLEN);

    // R6 edge inside guard window is dropped
    phase = "R6";
    next_start();
    drv_sync = 1'b1;
    repeat (3) @(negedge clk);
    check(ramp0 == 3, "R6", int'(ramp0), 3);
    drv_sync = 1'b0;
    measure(len, mid, wid);
    check(len == 117, "R6", len, 117);

    // R9 own pulse looped back is not an external edge
    phase = "R9";
    cfg0 = W'(80);
    loop_en = 1'b1;
    next_start();
    measure(len, mid, wid);
    check(len == 80, "R9", len, 80);
    measure(len, mid, wid);
    check(len == 80, "R9", len, 80);
    check(wid == PLEN, "R9", wid, PLEN);
    loop_en = 1'b0;

    // R10 master/slave pair
    phase = "R10";
    repeat (800) @(negedge clk);
    cnt_hi = 0; len = 0; peak = 0;
    for (int i = 0; i < 400; i++) begin
      if (out2) cnt_hi++;
      if (cs2) begin
        if (len > 0) check(i - len == 100, "R10", i - len, 100);
        check(int'(ramp1) == 53, "R10", int'(ramp1), 53);
        len = i; peak++;
      end
      @(negedge clk);
    end
    check(cnt_hi == 0, "R10", cnt_hi, 0);
    check(peak >= 3, "R10", peak, 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule